// File: doc/BRIEF.md
# Byte-Queue Serial Transmitter with Multi-Width Register Writes

This block is the sending half of a simple serial peripheral. Software loads bytes into a 16-entry byte queue through a small register port. One write access can carry one, two or four bytes, depending on which of three push registers it targets. The queue feeds a shifter that sends each byte on a single output line, least significant bit first. The time spent on each bit is set by a divider register.

Software can read the current queue level at any time. A status bit records the moment the queue runs dry. That bit is set only when the level steps from one entry to zero. A second status bit latches when a write was refused for lack of room. Both bits stay set until software clears them, and the drain bit is gated by an enable bit onto the interrupt line.

The intended use is as follows. Software fills the queue, then sleeps or polls until it is nearly empty. It uses the drain interrupt to learn that a whole burst has left the queue.

Top module: `txq_top`

## Requirements
- R1: After reset the level register reads 0, the status register reads 0, the interrupt output is 0, the busy output is 0 and the serial line is 1.
- R2: A write to address 0 queues wdata[7:0], a write to address 1 queues wdata[15:0] and a write to address 2 queues wdata[31:0]. Bytes are queued lowest byte first and leave in the order they were queued, across separate writes.
- R3: A push whose bytes would take the level above 16 is dropped in full. The level is unchanged and status bit 1 (overflow) becomes 1 and stays 1.
- R4: A read of address 3 returns the level in its low bits. Read data appears one cycle after the read strobe. A push and the serializer taking a byte in the same cycle change the level by the net amount.
- R5: Each byte is sent LSB first, and each bit is held for (divider + 1) clock cycles. The divider is written at address 6, bits 15:0. The line sits at 1 when idle. The busy output, also readable as status bit 2, is 1 while a byte is being shifted.
- R6: Status bit 0 (drained) becomes 1 only after the level goes from 1 to 0. A queue that stays empty, or that drains only part of the way, leaves it at 0.
- R7: The interrupt output equals status bit 0 AND the enable bit, which is address 5, bit 0.
- R8: Writing a 1 to status bit 0 or bit 1 at address 4 clears that bit. Writing a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| ser_out | output | 1 | Serial data line, idle high |
| tx_busy | output | 1 | A byte is being shifted out |
| irq | output | 1 | Drain interrupt, gated by the enable bit |

## Verification
The hardest states to reach are the ones where the queue sits exactly at its limit. In the normal case the serializer starts taking bytes as soon as they arrive, so the level never stays near the limit. The bench therefore sets the divider to a very long bit time, which holds the shifter on its first byte. It then issues back-to-back wide pushes to land on 15 entries, then 16, then one push too many. The same slow setting pins down a push that coincides with a pop, and lets the bench see the level stay at one. A moderate divider lets the queue drain partway before the bench reads the drained bit, so a premature interrupt would show up.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [2:0] {
    SEL_PUSH8  = 3'd0,
    SEL_PUSH16 = 3'd1,
    SEL_PUSH32 = 3'd2,
    SEL_LEVEL  = 3'd3,
    SEL_STAT   = 3'd4,
    SEL_IRQEN  = 3'd5,
    SEL_DIV    = 3'd6
  } reg_sel_e;

  // Number of bytes a write to the given register pushes.
  function automatic logic [2:0] push_bytes(input logic [2:0] sel);
    case (sel)
      3'(SEL_PUSH8):  return 3'd1;
      3'(SEL_PUSH16): return 3'd2;
      3'(SEL_PUSH32): return 3'd4;
      default:        return 3'd0;
    endcase
  endfunction

  // True when n more bytes still fit beside lvl queued ones.
  function automatic logic room_ok(input int unsigned lvl, input int unsigned n,
                                   input int unsigned cap);
    return (lvl + n) <= cap;
  endfunction

endpackage

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo #(
  parameter int unsigned DEPTH = 16,       // power of two
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic [7:0]    head,
  output logic          drop
);
  import txq_pkg::*;

  localparam int unsigned PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          fits, accept, do_pop;

  assign fits   = room_ok(int'(level), int'(push_n), DEPTH);
  assign accept = (push_n != 3'd0) && fits;
  assign drop   = (push_n != 3'd0) && !fits;
  assign do_pop = pop && (level != '0);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (accept && (3'(k) < push_n))
        mem[wr_ptr + PW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + PW'(push_n);
      if (do_pop) rd_ptr <= rd_ptr + PW'(1);
      level <= level + (accept ? LW'(push_n) : LW'(0)) - LW'(do_pop);
    end
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_drop_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> level == $past(level) - LW'($past(do_pop)));

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0);

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             have_data,
  input  logic [7:0]       head,
  output logic             pop,
  output logic             ser_out,
  output logic             busy
);
  logic [7:0]       shreg;
  logic [2:0]       bitcnt;
  logic [DIV_W-1:0] divcnt;
  logic             load, bit_end, last_bit;

  assign load     = !busy && have_data;
  assign pop      = load;
  assign bit_end  = busy && (divcnt == '0);
  assign last_bit = bit_end && (bitcnt == 3'd7);
  assign ser_out  = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '0;
      bitcnt <= '0;
      divcnt <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      shreg  <= head;
      bitcnt <= '0;
      divcnt <= div;
    end else if (last_bit) begin
      busy <= 1'b0;
    end else if (bit_end) begin
      shreg  <= {1'b0, shreg[7:1]};
      bitcnt <= bitcnt + 3'd1;
      divcnt <= div;
    end else if (busy) begin
      divcnt <= divcnt - DIV_W'(1);
    end
  end

  assert_load_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && ser_out == $past(head[0]));

  assert_shift_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !last_bit) |=> ser_out == $past(shreg[1]));

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> ser_out);

endmodule

// File: rtl/txq_csr.sv
module txq_csr #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [LW-1:0]    level,
  input  logic             drop,
  input  logic             busy,
  output logic [2:0]       push_n,
  output logic [31:0]      rdata,
  output logic [DIV_W-1:0] div,
  output logic             irq
);
  import txq_pkg::*;

  logic [LW-1:0] prev_level;
  logic          drain_evt, irq_stat, ovf, irq_en;
  logic          wr_stat;

  assign push_n    = wr_en ? push_bytes(addr) : 3'd0;
  assign wr_stat   = wr_en && (addr == 3'(SEL_STAT));
  // Drain edge: previous level one, current level zero.
  assign drain_evt = (prev_level == LW'(1)) && (level == '0);
  assign irq       = irq_stat & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_level <= '0;
      irq_stat   <= 1'b0;
      ovf        <= 1'b0;
      irq_en     <= 1'b0;
      div        <= '0;
      rdata      <= '0;
    end else begin
      prev_level <= level;
      if (drain_evt)                irq_stat <= 1'b1;
      else if (wr_stat && wdata[0]) irq_stat <= 1'b0;
      if (drop)                     ovf <= 1'b1;
      else if (wr_stat && wdata[1]) ovf <= 1'b0;
      if (wr_en && addr == 3'(SEL_IRQEN)) irq_en <= wdata[0];
      if (wr_en && addr == 3'(SEL_DIV))   div    <= wdata[DIV_W-1:0];
      if (rd_en) begin
        case (addr)
          3'(SEL_LEVEL): rdata <= 32'(level);
          3'(SEL_STAT):  rdata <= {29'd0, busy, ovf, irq_stat};
          3'(SEL_IRQEN): rdata <= {31'd0, irq_en};
          3'(SEL_DIV):   rdata <= 32'(div);
          default:       rdata <= '0;
        endcase
      end
    end
  end

  assert_drain_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |=> irq_stat);

  assert_drain_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(drain_evt));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(drop));

endmodule

// File: rtl/txq_top.sv
module txq_top #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ser_out,
  output logic        tx_busy,
  output logic        irq
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [2:0]       push_n;
  logic [LW-1:0]    level;
  logic [7:0]       head;
  logic             drop, pop;
  logic [DIV_W-1:0] div;

  txq_csr #(.DIV_W(DIV_W), .LW(LW)) csr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .level(level), .drop(drop), .busy(tx_busy),
    .push_n(push_n), .rdata(rdata), .div(div), .irq(irq)
  );

  txq_byte_fifo #(.DEPTH(DEPTH), .LW(LW)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_data(wdata),
    .pop(pop), .level(level), .head(head), .drop(drop)
  );

  txq_shifter #(.DIV_W(DIV_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .div(div), .have_data(level != '0),
    .head(head), .pop(pop), .ser_out(ser_out), .busy(tx_busy)
  );

endmodule

// File: tb/txq_top_tb_top.sv
module txq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ser_out, tx_busy, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd;
  logic [7:0]  got;

  always #2 clk = ~clk;  // 250 MHz

  txq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ser_out(ser_out), .tx_busy(tx_busy), .irq(irq)
  );

  // {register (0:8-bit,1:16-bit,2:32-bit push), divider, data}
  localparam logic [49:0] VEC [6] = '{
    {2'd0, 16'd0, 32'h0000_00A5},
    {2'd1, 16'd1, 32'h0000_3C96},
    {2'd2, 16'd2, 32'h8421_F00D},
    {2'd2, 16'd0, 32'h0123_4567},
    {2'd1, 16'd3, 32'hFFFF_0180},
    {2'd0, 16'd4, 32'hDEAD_BE5A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Samples one byte; each bit is expected to last d+1 cycles.
  task automatic capture(input int d, output logic [7:0] b);
    while (tx_busy !== 1'b1) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      b[k] = ser_out;
      repeat (d + 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1 serial line idle", 32'(ser_out), 32'd1);
    check("R1 busy low", 32'(tx_busy), 32'd0);
    check("R1 irq low", 32'(irq), 32'd0);
    do_read(3'd3, rd); check("R1 level zero", rd, 32'd0);
    do_read(3'd4, rd); check("R1 status zero", rd, 32'd0);
    repeat (20) @(negedge clk);
    do_read(3'd4, rd); check("R6 empty queue raises no drain", rd, 32'd0);

    // R2/R5: table of pushes, each byte checked on the line
    for (int i = 0; i < 6; i++) begin
      do_write(3'd6, 32'(VEC[i][47:32]));
      do_write(3'(VEC[i][49:48]), VEC[i][31:0]);
      for (int j = 0; j < (1 << VEC[i][49:48]); j++) begin
        capture(int'(VEC[i][47:32]), got);
        check("R2 R5 serial byte", 32'(got), 32'(VEC[i][8*j +: 8]));
      end
      check("R5 busy drops after byte", 32'(tx_busy), 32'd0);
      check("R5 line idles high", 32'(ser_out), 32'd1);
      repeat (3) @(negedge clk);
      do_read(3'd3, rd); check("R4 level after drain", rd, 32'd0);
    end

    // R2: FIFO order across writes
    do_reset();
    do_write(3'd0, 32'h0000_0011);
    do_write(3'd1, 32'h0000_3322);
    capture(0, got); check("R2 order byte0", 32'(got), 32'h11);
    capture(0, got); check("R2 order byte1", 32'(got), 32'h22);
    capture(0, got); check("R2 order byte2", 32'(got), 32'h33);

    // R6/R7/R8: partial drain, full drain, enable, clear
    do_reset();
    do_write(3'd6, 32'd50);
    do_write(3'd1, 32'h0000_BBAA);
    repeat (100) @(negedge clk);
    do_read(3'd4, rd); check("R6 partial drain no status", rd & 32'h1, 32'd0);
    check("R5 busy status bit", rd & 32'h4, 32'h4);
    do_read(3'd3, rd); check("R4 level mid drain", rd, 32'd1);
    repeat (1000) @(negedge clk);
    do_read(3'd4, rd); check("R6 drain sets status", rd, 32'd1);
    check("R7 irq masked", 32'(irq), 32'd0);
    do_write(3'd5, 32'd1);
    check("R7 irq enabled", 32'(irq), 32'd1);
    do_write(3'd4, 32'd0);
    check("R8 zero write keeps status", 32'(irq), 32'd1);
    do_write(3'd4, 32'd1);
    check("R8 irq cleared", 32'(irq), 32'd0);
    do_read(3'd4, rd); check("R8 status cleared", rd, 32'd0);

    // R3: overflow at the limit with the shifter held on its first byte
    do_reset();
    do_write(3'd6, 32'd1000);
    do_write(3'd2, 32'h0403_0201);
    do_write(3'd2, 32'h0807_0605);
    do_write(3'd2, 32'h0C0B_0A09);
    do_write(3'd2, 32'h100F_0E0D);
    do_read(3'd3, rd); check("R4 level net after pop", rd, 32'd15);
    do_write(3'd1, 32'h0000_AAAA);
    do_read(3'd3, rd); check("R3 dropped word keeps level", rd, 32'd15);
    do_read(3'd4, rd); check("R3 overflow set", rd & 32'h2, 32'h2);
    do_write(3'd0, 32'h0000_0055);
    do_read(3'd3, rd); check("R3 single byte fills to 16", rd, 32'd16);
    do_write(3'd0, 32'h0000_0066);
    do_read(3'd3, rd); check("R3 full queue rejects", rd, 32'd16);
    do_write(3'd4, 32'd2);
    do_read(3'd4, rd); check("R8 overflow cleared", rd & 32'h3, 32'd0);

    // R4: push in the same cycle as the pop
    do_reset();
    do_write(3'd6, 32'd1000);
    do_write(3'd0, 32'h0000_0001);
    do_write(3'd0, 32'h0000_0002);
    do_read(3'd3, rd); check("R4 same-cycle push and pop", rd, 32'd1);
    do_read(3'd4, rd); check("R6 one to one raises no drain", rd & 32'h1, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule